// File: doc/BRIEF.md
# Fixed-Point Multiplier with Requantizer

This block multiplies two signed two's-complement fixed-point operands and returns the product in a narrower output format. Each operand, and the output, has its own compile-time format, given by a total word length and a fraction bit count. The integer bit count follows from these two, because every format also carries one sign bit. A format with I integer bits and F fraction bits covers -2^I up to but not including 2^I, in steps of 2^-F. The position of the binary point is fixed at elaboration. At run time the block does only a plain signed integer multiply, followed by a shift.

The full product is exact. Its width is the sum of the two operand widths, and its fraction bit count is the sum of the two operand fraction bit counts. The product is then requantized in two steps. First, a rounding stage drops the surplus fraction bits, using the mode selected for this operand pair. Then an overflow stage fits the rounded value into the output width, either by wrapping or by clamping. A flag reports whenever the overflow stage changed the value. The two mode selects are sampled together with the operands, so every product in a back-to-back stream can use its own modes.

With the default parameters, operand A is (8 bits, 4 fraction), operand B is (8 bits, 2 fraction) and the output is (10 bits, 4 fraction). The requantizer therefore drops two product bits.

Top module: `fxq_mul_requant`

## Requirements
- R1: The output equals the exact signed product of the raw operand codes, shifted right by (A fraction + B fraction - output fraction) bits and then rounded and fitted. For example, A code 105 (6.5625) times B code 17 (4.25) gives 27.890625, which becomes output code 446 in truncation mode.
- R2: A result appears on `out_y`/`out_ovf` with `out_valid` high exactly two clock edges after the edge that samples `in_valid` high. A low `in_valid` gives a low `out_valid` two edges later.
- R3: While `rst` is high at a clock edge, `out_valid` is cleared. It stays low until a valid input has had time to pass through the block.
- R4: Rounding mode code 00 truncates toward minus infinity, and so does code 11. The dropped bits are simply discarded.
- R5: Rounding mode code 01 rounds half up. One is added to the kept value when the dropped bits are at least one half LSB, so an exact tie moves toward plus infinity.
- R6: Rounding mode code 10 rounds half to even. One is added when the dropped bits exceed one half LSB. On an exact tie, one is added only if the kept value is odd.
- R7: Overflow mode code 00 wraps. The output is the low output-width bits of the rounded value, and `out_ovf` is high only when that differs from the rounded value.
- R8: Overflow mode code 01 clamps to the full two's-complement range, -2^(WL-1) through 2^(WL-1)-1. `out_ovf` is high exactly when the clamp was applied.
- R9: Overflow mode codes 10 and 11 clamp symmetrically, to plus or minus (2^(WL-1)-1). The most negative code is never output, and a rounded value equal to it is raised by one with `out_ovf` high.
- R10: A rounding carry that pushes the value past the output range is seen by the overflow stage in the same cycle. For example, a tie just below the maximum clamps with `out_ovf` high in mode 01, but not in truncation mode.
- R11: Each result uses the mode selects sampled with its own operands, even when the modes change on every cycle of a back-to-back stream.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all state changes on the rising edge |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Operands and modes are sampled when high |
| in_a | input | A_WL | Operand A, signed fixed-point code |
| in_b | input | B_WL | Operand B, signed fixed-point code |
| rnd_mode | input | 2 | Rounding select: 00/11 truncate, 01 half up, 10 half even |
| sat_mode | input | 2 | Overflow select: 00 wrap, 01 full-range clamp, 10/11 symmetric clamp |
| out_valid | output | 1 | Result strobe, two cycles after the input strobe |
| out_y | output | Y_WL | Requantized product, signed fixed-point code |
| out_ovf | output | 1 | High when the overflow stage changed the value |

## Verification
The rounding increment and the overflow decision can meet in the same cycle. That happens when a dropped fraction is an exact tie and the kept value already sits at the top of the output range. The bench provokes this with 66 x 31 = 2046, which is a tie on the maximum code 511. It judges the result per mode: truncation keeps 511 with no flag, while round-half-up and round-half-even carry to 512, which clamps back to 511 or wraps to -512, with the flag set. The most negative times most negative product, and a product that lands exactly on the most negative code, probe how the two clamp styles treat the edge of the range.

// File: rtl/fxq_pkg.sv
package fxq_pkg;

  typedef enum logic [1:0] {
    RND_TRUNC     = 2'b00,
    RND_HALF_UP   = 2'b01,
    RND_HALF_EVEN = 2'b10,
    RND_TRUNC_ALT = 2'b11
  } rnd_e;

  typedef enum logic [1:0] {
    SAT_WRAP     = 2'b00,
    SAT_FULL     = 2'b01,
    SAT_SYM      = 2'b10,
    SAT_SYM_ALT  = 2'b11
  } sat_e;

  function automatic int fxq_max(input int x, input int y);
    return (x > y) ? x : y;
  endfunction

endpackage

// File: rtl/fxq_mul_stage.sv
module fxq_mul_stage #(
  parameter int A_WL = 8,
  parameter int B_WL = 8,
  localparam int P_WL = A_WL + B_WL
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   in_valid,
  input  logic [A_WL-1:0]        in_a,
  input  logic [B_WL-1:0]        in_b,
  input  logic [1:0]             in_rnd,
  input  logic [1:0]             in_sat,
  output logic                   p_valid,
  output logic signed [P_WL-1:0] p_prod,
  output logic [1:0]             p_rnd,
  output logic [1:0]             p_sat
);

  logic signed [P_WL-1:0] a_ext;
  logic signed [P_WL-1:0] b_ext;

  // both operands widened to the product width so the multiply is exact
  assign a_ext = {{B_WL{in_a[A_WL-1]}}, in_a};
  assign b_ext = {{A_WL{in_b[B_WL-1]}}, in_b};

  always_ff @(posedge clk) begin
    if (rst) begin
      p_valid <= 1'b0;
      p_prod  <= '0;
      p_rnd   <= 2'b00;
      p_sat   <= 2'b00;
    end else begin
      p_valid <= in_valid;
      if (in_valid) begin
        p_prod <= a_ext * b_ext;
        p_rnd  <= in_rnd;
        p_sat  <= in_sat;
      end
    end
  end

endmodule

// File: rtl/fxq_rounder.sv
module fxq_rounder
  import fxq_pkg::*;
#(
  parameter int P_WL = 16,
  parameter int DROP = 2,
  localparam int R_WL = (DROP > 0) ? (P_WL - DROP + 1) : (P_WL - DROP)
) (
  input  logic signed [P_WL-1:0] p,
  input  logic [1:0]             mode,
  output logic signed [R_WL-1:0] r
);

  generate
    if (DROP > 0) begin : g_drop
      localparam int K_WL = P_WL - DROP;
      logic [K_WL-1:0] kept;
      logic [DROP:0]   low_x;
      logic            half;
      logic            rest;
      logic            inc;

      assign kept  = p[P_WL-1:DROP];
      assign half  = p[DROP-1];
      assign low_x = {p[DROP-1:0], 1'b0};
      assign rest  = |low_x[DROP-1:0];

      always_comb begin
        unique case (rnd_e'(mode))
          RND_HALF_UP:   inc = half;
          RND_HALF_EVEN: inc = half & (rest | kept[0]);
          default:       inc = 1'b0;
        endcase
      end

      // one guard bit so a carry out of the kept value is never lost
      assign r = $signed({kept[K_WL-1], kept}) + $signed({{K_WL{1'b0}}, inc});
    end else if (DROP == 0) begin : g_keep
      assign r = p;
    end else begin : g_widen
      assign r = {p, {(-DROP){1'b0}}};
    end
  endgenerate

endmodule

// File: rtl/fxq_saturator.sv
module fxq_saturator
  import fxq_pkg::*;
#(
  parameter int R_WL = 15,
  parameter int Y_WL = 10,
  localparam int E_WL = fxq_max(R_WL, Y_WL) + 1
) (
  input  logic signed [R_WL-1:0] r,
  input  logic [1:0]             mode,
  output logic [Y_WL-1:0]        y,
  output logic                   ovf
);

  logic signed [E_WL-1:0] e;
  logic signed [E_WL-1:0] hi_lim;
  logic signed [E_WL-1:0] lo_full;
  logic signed [E_WL-1:0] lo_sym;
  logic signed [E_WL-1:0] lo_lim;
  logic signed [E_WL-1:0] wrap_back;
  logic        [Y_WL-1:0] wrapped;

  assign e       = {{(E_WL-R_WL){r[R_WL-1]}}, r};
  assign hi_lim  = {{(E_WL-Y_WL+1){1'b0}}, {(Y_WL-1){1'b1}}};
  assign lo_full = {{(E_WL-Y_WL+1){1'b1}}, {(Y_WL-1){1'b0}}};
  assign lo_sym  = lo_full + E_WL'(1);
  assign lo_lim  = mode[1] ? lo_sym : lo_full;

  assign wrapped   = e[Y_WL-1:0];
  assign wrap_back = {{(E_WL-Y_WL){wrapped[Y_WL-1]}}, wrapped};

  always_comb begin
    if (sat_e'(mode) == SAT_WRAP) begin
      y   = wrapped;
      ovf = (wrap_back != e);
    end else if (e > hi_lim) begin
      y   = hi_lim[Y_WL-1:0];
      ovf = 1'b1;
    end else if (e < lo_lim) begin
      y   = lo_lim[Y_WL-1:0];
      ovf = 1'b1;
    end else begin
      y   = wrapped;
      ovf = 1'b0;
    end
  end

endmodule

// File: rtl/fxq_mul_requant.sv
module fxq_mul_requant #(
  parameter int A_WL  = 8,
  parameter int A_FWL = 4,
  parameter int B_WL  = 8,
  parameter int B_FWL = 2,
  parameter int Y_WL  = 10,
  parameter int Y_FWL = 4
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            in_valid,
  input  logic [A_WL-1:0] in_a,
  input  logic [B_WL-1:0] in_b,
  input  logic [1:0]      rnd_mode,
  input  logic [1:0]      sat_mode,
  output logic            out_valid,
  output logic [Y_WL-1:0] out_y,
  output logic            out_ovf
);

  localparam int P_WL  = A_WL + B_WL;
  localparam int P_FWL = A_FWL + B_FWL;
  localparam int DROP  = P_FWL - Y_FWL;
  localparam int R_WL  = (DROP > 0) ? (P_WL - DROP + 1) : (P_WL - DROP);

  logic                   p_valid;
  logic signed [P_WL-1:0] p_prod;
  logic [1:0]             p_rnd;
  logic [1:0]             p_sat;
  logic signed [R_WL-1:0] rounded;
  logic [Y_WL-1:0]        fitted;
  logic                   fit_ovf;

  fxq_mul_stage #(.A_WL(A_WL), .B_WL(B_WL)) u_mul (
    .clk      (clk),
    .rst      (rst),
    .in_valid (in_valid),
    .in_a     (in_a),
    .in_b     (in_b),
    .in_rnd   (rnd_mode),
    .in_sat   (sat_mode),
    .p_valid  (p_valid),
    .p_prod   (p_prod),
    .p_rnd    (p_rnd),
    .p_sat    (p_sat)
  );

  fxq_rounder #(.P_WL(P_WL), .DROP(DROP)) u_rnd (
    .p    (p_prod),
    .mode (p_rnd),
    .r    (rounded)
  );

  fxq_saturator #(.R_WL(R_WL), .Y_WL(Y_WL)) u_sat (
    .r    (rounded),
    .mode (p_sat),
    .y    (fitted),
    .ovf  (fit_ovf)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= 1'b0;
      out_y     <= '0;
      out_ovf   <= 1'b0;
    end else begin
      out_valid <= p_valid;
      if (p_valid) begin
        out_y   <= fitted;
        out_ovf <= fit_ovf;
      end
    end
  end

endmodule

// File: rtl/fxq_mul_requant_chk.sv
module fxq_mul_requant_chk #(
  parameter int Y_WL = 10
) (
  input logic            clk,
  input logic            rst,
  input logic            in_valid,
  input logic [1:0]      sat_mode,
  input logic            out_valid,
  input logic [Y_WL-1:0] out_y,
  input logic            out_ovf
);

  logic [1:0]      sat_d1;
  logic [1:0]      sat_d2;
  logic [Y_WL-1:0] code_min;
  logic [Y_WL-1:0] code_max;

  assign code_min = {1'b1, {(Y_WL-1){1'b0}}};
  assign code_max = {1'b0, {(Y_WL-1){1'b1}}};

  always_ff @(posedge clk) begin
    if (rst) begin
      sat_d1 <= 2'b00;
      sat_d2 <= 2'b00;
    end else begin
      sat_d1 <= sat_mode;
      sat_d2 <= sat_d1;
    end
  end

  // R2: strobe arrives two edges after the input strobe
  a_r2_valid_follows: assert property (@(posedge clk) disable iff (rst)
    in_valid |-> ##2 out_valid);

  // R2: no strobe in means no strobe out
  a_r2_idle_follows: assert property (@(posedge clk) disable iff (rst)
    !in_valid |-> ##2 !out_valid);

  // R9: symmetric clamp never emits the most negative code
  a_r9_no_min_code: assert property (@(posedge clk) disable iff (rst)
    (out_valid && sat_d2[1]) |-> (out_y != code_min));

  // R8: a flagged full-range clamp lands on one of the range ends
  a_r8_clamp_at_end: assert property (@(posedge clk) disable iff (rst)
    (out_valid && out_ovf && sat_d2 == 2'b01) |-> (out_y == code_max || out_y == code_min));

endmodule

bind fxq_mul_requant fxq_mul_requant_chk #(.Y_WL(Y_WL)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .in_valid  (in_valid),
  .sat_mode  (sat_mode),
  .out_valid (out_valid),
  .out_y     (out_y),
  .out_ovf   (out_ovf)
);

// File: tb/sim_fxq_mul_requant.sv
`timescale 1ns/1ps
module sim_fxq_mul_requant;

  localparam int A_WL  = 8;
  localparam int A_FWL = 4;
  localparam int B_WL  = 8;
  localparam int B_FWL = 2;
  localparam int Y_WL  = 10;
  localparam int Y_FWL = 4;
  localparam int DROP  = A_FWL + B_FWL - Y_FWL;
  localparam int N_STREAM = 200;

  logic            clk = 1'b0;
  logic            rst = 1'b1;
  logic            in_valid = 1'b0;
  logic [A_WL-1:0] in_a = '0;
  logic [B_WL-1:0] in_b = '0;
  logic [1:0]      rnd_mode = 2'b00;
  logic [1:0]      sat_mode = 2'b00;
  logic            out_valid;
  logic [Y_WL-1:0] out_y;
  logic            out_ovf;

  int  n_checks = 0;
  int  n_fails  = 0;
  bit  done     = 1'b0;

  always #2.5 clk = ~clk;

  fxq_mul_requant #(
    .A_WL(A_WL), .A_FWL(A_FWL), .B_WL(B_WL), .B_FWL(B_FWL),
    .Y_WL(Y_WL), .Y_FWL(Y_FWL)
  ) u0 (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_a(in_a), .in_b(in_b),
    .rnd_mode(rnd_mode), .sat_mode(sat_mode),
    .out_valid(out_valid), .out_y(out_y), .out_ovf(out_ovf)
  );

  // integer reference: exact product, scaled, rounded, fitted
  function automatic void model(input int a, input int b, input int rm, input int sm,
                                output int y, output bit ovf);
    longint p, k, fr, half, r, hi, lo, w, span;
    p    = longint'(a) * longint'(b);
    k    = p >>> DROP;
    fr   = p - (k <<< DROP);
    half = longint'(1) <<< (DROP - 1);
    r    = k;
    if (rm == 1 && fr >= half) r = k + 1;
    if (rm == 2 && (fr > half || (fr == half && (k % 2) != 0))) r = k + 1;
    span = longint'(1) <<< Y_WL;
    hi   = (span / 2) - 1;
    lo   = (sm >= 2) ? -hi : -(span / 2);
    if (sm == 0) begin
      w = r % span;
      if (w < 0) w = w + span;
      if (w > hi) w = w - span;
      y   = int'(w);
      ovf = (w != r);
    end else if (r > hi) begin
      y = int'(hi); ovf = 1'b1;
    end else if (r < lo) begin
      y = int'(lo); ovf = 1'b1;
    end else begin
      y = int'(r); ovf = 1'b0;
    end
  endfunction

  task automatic check(input string req, input bit exp_v, input int exp_y, input bit exp_o);
    int got_y;
    got_y = int'($signed(out_y));
    n_checks++;
    if (out_valid !== exp_v || (exp_v && (got_y != exp_y || out_ovf !== exp_o))) begin
      n_fails++;
      $display("FAIL %s: got valid=%0b y=%0d ovf=%0b, expected valid=%0b y=%0d ovf=%0b",
               req, out_valid, got_y, out_ovf, exp_v, exp_y, exp_o);
    end
  endtask

  task automatic drive(input bit v, input int a, input int b, input int rm, input int sm);
    in_valid = v;
    in_a     = a[A_WL-1:0];
    in_b     = b[B_WL-1:0];
    rnd_mode = rm[1:0];
    sat_mode = sm[1:0];
  endtask

  // single vector: drive, wait two edges, check against model and optional literal
  task automatic one(input string req, input int a, input int b, input int rm, input int sm,
                     input bit use_lit, input int lit_y, input bit lit_o);
    int  my;
    bit  mo;
    model(a, b, rm, sm, my, mo);
    @(negedge clk); drive(1'b1, a, b, rm, sm);
    @(negedge clk); drive(1'b0, 0, 0, 0, 0);
    @(negedge clk);
    if (use_lit) check(req, 1'b1, lit_y, lit_o);
    else         check(req, 1'b1, my, mo);
    @(negedge clk);
    check({req, " R2 strobe drop"}, 1'b0, 0, 1'b0);
  endtask

  task automatic t_reset();
    @(negedge clk);
    check("R3 in reset", 1'b0, 0, 1'b0);
    @(negedge clk); rst = 1'b0;
    @(negedge clk);
    check("R3 after reset", 1'b0, 0, 1'b0);
  endtask

  task automatic t_reference();
    one("R1 6.5625*4.25 trunc", 105, 17, 0, 1, 1'b1, 446, 1'b0);
    one("R1 1.0*2.0 exact", 16, 8, 1, 1, 1'b1, 32, 1'b0);
    one("R1 zero times min", 0, -128, 2, 2, 1'b1, 0, 1'b0);
  endtask

  task automatic t_rounding();
    one("R4 tie trunc", 1, 6, 0, 1, 1'b1, 1, 1'b0);
    one("R4 trunc alt code 11", 1, 6, 3, 1, 1'b1, 1, 1'b0);
    one("R4 negative floor", 1, -3, 0, 1, 1'b1, -1, 1'b0);
    one("R5 tie up even kept", 1, 2, 1, 1, 1'b1, 1, 1'b0);
    one("R5 tie up odd kept", 1, 6, 1, 1, 1'b1, 2, 1'b0);
    one("R5 negative tie up", 1, -2, 1, 1, 1'b1, 0, 1'b0);
    one("R6 tie even kept stays", 1, 2, 2, 1, 1'b1, 0, 1'b0);
    one("R6 tie odd kept rises", 1, 6, 2, 1, 1'b1, 2, 1'b0);
    one("R6 negative tie odd kept", 1, -2, 2, 1, 1'b1, 0, 1'b0);
    one("R6 above half", 1, 3, 2, 1, 1'b1, 1, 1'b0);
  endtask

  task automatic t_overflow();
    one("R7 min*min wrap", -128, -128, 0, 0, 1'b1, 0, 1'b1);
    one("R8 min*min full clamp", -128, -128, 0, 1, 1'b1, 511, 1'b1);
    one("R9 min*min sym clamp", -128, -128, 0, 2, 1'b1, 511, 1'b1);
    one("R7 neg wrap", -128, 127, 0, 0, 1'b1, 32, 1'b1);
    one("R8 neg full clamp", -128, 127, 0, 1, 1'b1, -512, 1'b1);
    one("R9 neg sym clamp", -128, 127, 0, 3, 1'b1, -511, 1'b1);
    one("R7 exact min wrap", -128, 16, 0, 0, 1'b1, -512, 1'b0);
    one("R8 exact min kept", -128, 16, 0, 1, 1'b1, -512, 1'b0);
    one("R9 exact min raised", -128, 16, 0, 2, 1'b1, -511, 1'b1);
  endtask

  task automatic t_round_carry();
    one("R10 tie at max trunc", 66, 31, 0, 1, 1'b1, 511, 1'b0);
    one("R10 tie at max up clamp", 66, 31, 1, 1, 1'b1, 511, 1'b1);
    one("R10 tie at max even wrap", 66, 31, 2, 0, 1'b1, -512, 1'b1);
    one("R10 tie at max even sym", 66, 31, 2, 2, 1'b1, 511, 1'b1);
  endtask

  // back-to-back stream, modes changing each cycle, some idle slots
  task automatic t_stream();
    int  ea[N_STREAM];
    int  eb[N_STREAM];
    int  er[N_STREAM];
    int  es[N_STREAM];
    bit  ev[N_STREAM];
    for (int i = 0; i < N_STREAM; i++) begin
      ea[i] = int'($signed(8'($urandom())));
      eb[i] = int'($signed(8'($urandom())));
      er[i] = i % 4;
      es[i] = (i / 4) % 4;
      ev[i] = (i % 7) != 3;
    end
    for (int i = 0; i < N_STREAM + 2; i++) begin
      @(negedge clk);
      if (i >= 2) begin
        int my;
        bit mo;
        model(ea[i-2], eb[i-2], er[i-2], es[i-2], my, mo);
        check("R11 stream with R2 timing", ev[i-2], my, mo);
      end
      if (i < N_STREAM) drive(ev[i], ea[i], eb[i], er[i], es[i]);
      else              drive(1'b0, 0, 0, 0, 0);
    end
  endtask

  initial begin
    t_reset();
    t_reference();
    t_rounding();
    t_overflow();
    t_round_carry();
    t_stream();
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_checks++;
      n_fails++;
      $display("FAIL watchdog: got no completion, expected completion within 20000 cycles");
      $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
      $finish;
    end
  end

endmodule